// File: doc/BRIEF.md
# Push-Button Step and Auto-Repeat Controller

This block turns two active-high push-button levels into one-cycle step strobes for a position register. One button raises the position and the other lowers it. The block measures how long a button has stayed high. A high level that ends too early is treated as contact bounce and is dropped. A level that stays high long enough gives exactly one step. If the button is then kept pressed past a longer hold time, the block repeats the step at a fixed interval until the button is let go.

Both button inputs pass through a two-flop synchronizer before any timing is measured. All three intervals are parameters given in clock cycles, and each must be at least 2. In the text below, an "n-th held cycle" means the n-th consecutive clock cycle in which exactly one synchronized button is high, the lock is low, and the same button has been held throughout. A strobe is registered, so it appears in the cycle after the held cycle that triggers it. An external lock input, raised while the position is being written to storage, stops new steps.

Top module: `pbtn_stepper`

## Requirements
- R1: A change on either button input reaches `active_o` two clock edges later, and `active_o` is high whenever either synchronized button is high.
- R2: A high run shorter than QUAL_CYC held cycles gives no strobe.
- R3: On the QUAL_CYC-th held cycle of the up button, `step_up_o` rises for exactly one cycle in the following cycle.
- R4: If the button is still held, the next strobe comes on held cycle QUAL_CYC+HOLD_CYC.
- R5: After that, a strobe comes every RPT_CYC held cycles for as long as the button stays held.
- R6: The down button follows the same timing as the up button but strobes `step_dn_o` only.
- R7: While `lock_i` is high in a cycle, no strobe follows in the next cycle, and the held-cycle count starts again from zero.
- R8: A cycle with both synchronized buttons high gives no strobe next cycle and restarts the held-cycle count.
- R9: A release of even one synchronized cycle restarts both the qualification and the auto-repeat timing.
- R10: `step_up_o` and `step_dn_o` are never high together, and no strobe lasts longer than one cycle.
- R11: During and just after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_btn_i | input | 1 | Raise button, active high, asynchronous |
| dn_btn_i | input | 1 | Lower button, active high, asynchronous |
| lock_i | input | 1 | Storage busy, blocks steps while high (synchronous) |
| step_up_o | output | 1 | One-cycle increment strobe |
| step_dn_o | output | 1 | One-cycle decrement strobe |
| active_o | output | 1 | Either synchronized button is high |

## Verification
The checker runs on every cycle and covers the safety rules. It confirms that the two strobes never coincide and that no strobe lasts more than one cycle. It also confirms that no strobe follows a locked cycle, a cycle with both buttons high, or a cycle with both buttons low, and that each strobe's direction matches the button that was held. The timing rules cannot be checked that way: the exact cycle of the qualifying step, the hold-to-repeat delay, the repeat interval, and the restart after a one-cycle release. The bench covers these with scenarios that compare the outputs against a behavioural held-cycle model, and with strobe counts computed from the run lengths.

// File: rtl/pbtn_pkg.sv
package pbtn_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_QUAL = 2'd1,
        PH_HOLD = 2'd2,
        PH_RPT  = 2'd3
    } phase_e;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;
endpackage

// File: rtl/pbtn_sync.sv
module pbtn_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[s] <= '0;
                else         stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[s] <= '0;
                else         stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pbtn_classify.sv
module pbtn_classify
    import pbtn_pkg::*;
(
    input  logic up_i,
    input  logic dn_i,
    output logic single_o,
    output dir_e dir_o
);
    always_comb begin
        single_o = up_i ^ dn_i;
        dir_o    = dn_i ? DIR_DN : DIR_UP;
    end
endmodule

// File: rtl/pbtn_seq.sv
module pbtn_seq
    import pbtn_pkg::*;
#(
    parameter int QUAL_CYC = 400_000,
    parameter int HOLD_CYC = 50_000_000,
    parameter int RPT_CYC  = 7_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic single_i,
    input  dir_e dir_i,
    input  logic lock_i,
    output logic step_up_o,
    output logic step_dn_o
);
    localparam int MAX_QH = (QUAL_CYC > HOLD_CYC) ? QUAL_CYC : HOLD_CYC;
    localparam int MAXC   = (MAX_QH > RPT_CYC) ? MAX_QH : RPT_CYC;
    localparam int CW     = (MAXC > 2) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] Q_LAST = CW'(QUAL_CYC - 1);
    localparam logic [CW-1:0] H_LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] R_LAST = CW'(RPT_CYC - 1);

    typedef struct packed {
        phase_e          phase;
        dir_e            dir;
        logic [CW-1:0]   cnt;
        logic            up;
        logic            dn;
    } st_t;

    st_t st_d, st_q;
    logic abort_d;
    logic fire_d;

    always_comb begin
        st_d    = st_q;
        st_d.up = 1'b0;
        st_d.dn = 1'b0;
        fire_d  = 1'b0;
        abort_d = !single_i || lock_i ||
                  ((st_q.phase != PH_IDLE) && (dir_i != st_q.dir));
        if (abort_d) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    st_d.phase = PH_QUAL;
                    st_d.dir   = dir_i;
                    st_d.cnt   = CW'(1);
                end
                PH_QUAL: begin
                    if (st_q.cnt == Q_LAST) begin
                        fire_d     = 1'b1;
                        st_d.phase = PH_HOLD;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CW'(1);
                    end
                end
                PH_HOLD: begin
                    if (st_q.cnt == H_LAST) begin
                        fire_d     = 1'b1;
                        st_d.phase = PH_RPT;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CW'(1);
                    end
                end
                PH_RPT: begin
                    if (st_q.cnt == R_LAST) begin
                        fire_d   = 1'b1;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CW'(1);
                    end
                end
                default: begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end
            endcase
            st_d.up = fire_d && (st_q.phase == PH_IDLE ? 1'b0 : st_q.dir == DIR_UP);
            st_d.dn = fire_d && (st_q.phase == PH_IDLE ? 1'b0 : st_q.dir == DIR_DN);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, dir: DIR_UP, cnt: '0, up: 1'b0, dn: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign step_up_o = st_q.up;
    assign step_dn_o = st_q.dn;
endmodule

// File: rtl/pbtn_stepper.sv
module pbtn_stepper
    import pbtn_pkg::*;
#(
    parameter int QUAL_CYC    = 400_000,
    parameter int HOLD_CYC    = 50_000_000,
    parameter int RPT_CYC     = 7_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic up_btn_i,
    input  logic dn_btn_i,
    input  logic lock_i,
    output logic step_up_o,
    output logic step_dn_o,
    output logic active_o
);
    localparam int NBTN = 2;

    logic [NBTN-1:0] btn_s;
    logic            up_s;
    logic            dn_s;
    logic            single_s;
    dir_e            dir_s;

    pbtn_sync #(.W(NBTN), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({dn_btn_i, up_btn_i}),
        .sync_o  (btn_s)
    );

    assign up_s = btn_s[0];
    assign dn_s = btn_s[1];

    pbtn_classify u_classify (
        .up_i     (up_s),
        .dn_i     (dn_s),
        .single_o (single_s),
        .dir_o    (dir_s)
    );

    pbtn_seq #(
        .QUAL_CYC (QUAL_CYC),
        .HOLD_CYC (HOLD_CYC),
        .RPT_CYC  (RPT_CYC)
    ) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .single_i  (single_s),
        .dir_i     (dir_s),
        .lock_i    (lock_i),
        .step_up_o (step_up_o),
        .step_dn_o (step_dn_o)
    );

    assign active_o = up_s | dn_s;
endmodule

// File: rtl/pbtn_stepper_chk.sv
module pbtn_stepper_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic lock_i,
    input logic up_s,
    input logic dn_s,
    input logic step_up_o,
    input logic step_dn_o
);
    p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(step_up_o && step_dn_o));

    p_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_up_o || step_dn_o) |=> !(step_up_o || step_dn_o));

    p_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_i |=> !(step_up_o || step_dn_o));

    p_both_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (up_s && dn_s) |=> !(step_up_o || step_dn_o));

    p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!up_s && !dn_s) |=> !(step_up_o || step_dn_o));

    p_updir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(step_up_o) |-> $past(up_s));

    p_dndir_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(step_dn_o) |-> $past(dn_s));
endmodule

bind pbtn_stepper pbtn_stepper_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (lock_i),
    .up_s      (up_s),
    .dn_s      (dn_s),
    .step_up_o (step_up_o),
    .step_dn_o (step_dn_o)
);

// File: tb/pbtn_stepper_tb.sv
`timescale 1ns/1ps
module pbtn_stepper_tb_top;
    localparam int Q = 5;
    localparam int H = 20;
    localparam int R = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up = 1'b0, dn = 1'b0, lk = 1'b0;
    logic step_up, step_dn, active;

    int total = 0;
    int bad = 0;
    int n_up = 0, n_dn = 0;
    string cur_req = "R11";

    // behavioural model state
    logic m1u = 0, m1d = 0, m2u = 0, m2d = 0;
    int   held = 0;
    logic mdir = 0;
    logic e_up = 0, e_dn = 0, e_act = 0;

    always #10 clk = ~clk;

    pbtn_stepper #(.QUAL_CYC(Q), .HOLD_CYC(H), .RPT_CYC(R)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .up_btn_i(up), .dn_btn_i(dn),
        .lock_i(lk), .step_up_o(step_up), .step_dn_o(step_dn), .active_o(active)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_count(input int len);
        int c = 0;
        if (len >= Q) c++;
        if (len >= Q + H) c++;
        if (len > Q + H) c += (len - Q - H) / R;
        return c;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1u = 0; m1d = 0; m2u = 0; m2d = 0;
            held = 0; mdir = 0; e_up = 0; e_dn = 0; e_act = 0;
        end else begin
            e_up = 0; e_dn = 0;
            if (!(m2u ^ m2d) || lk) held = 0;
            else if (held > 0 && m2d != mdir) held = 0;
            else begin
                if (held == 0) mdir = m2d;
                held++;
                if (held == Q || held == Q + H ||
                    (held > Q + H && (held - Q - H) % R == 0)) begin
                    e_up = !mdir;
                    e_dn = mdir;
                end
            end
            m2u = m1u; m2d = m1d;
            m1u = up;  m1d = dn;
            e_act = m2u | m2d;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " step_up"}, step_up, e_up);
            chk({cur_req, " step_dn"}, step_dn, e_dn);
            chk("R1 active", active, e_act);
            if (step_up) n_up++;
            if (step_dn) n_dn++;
        end
    end

    task automatic drive(input logic u, input logic d, input logic l, input int cyc);
        up = u; dn = d; lk = l;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic clear_counts();
        n_up = 0; n_dn = 0;
    endtask

    task automatic run_up(input string req, input int len);
        cur_req = req;
        clear_counts();
        drive(1, 0, 0, len);
        drive(0, 0, 0, 6);
        chk({req, " up count"}, n_up, exp_count(len));
        chk({req, " no down"}, n_dn, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset up", step_up, 0);
        chk("R11 reset dn", step_dn, 0);
        chk("R11 reset act", active, 0);
        rst_n = 1'b1;
        drive(0, 0, 0, 4);

        // R1: two-edge synchronizer latency on active_o
        cur_req = "R1";
        up = 1'b1;
        @(negedge clk); chk("R1 after one edge", active, 0);
        @(negedge clk); chk("R1 after two edges", active, 1);
        drive(0, 0, 0, 8);

        // R2: bounce pulses shorter than qualification
        cur_req = "R2";
        clear_counts();
        for (int i = 0; i < 3; i++) begin
            drive(1, 0, 0, Q - 1);
            drive(0, 0, 0, 2);
        end
        drive(0, 0, 0, 4);
        chk("R2 bounce count", n_up, 0);

        run_up("R3", Q);
        run_up("R3", Q + 3);
        run_up("R4", Q + H - 1);
        run_up("R4", Q + H);
        run_up("R5", Q + H + 4 * R + 3);

        // R6: down button
        cur_req = "R6";
        clear_counts();
        drive(0, 1, 0, 40);
        drive(0, 0, 0, 6);
        chk("R6 dn count", n_dn, exp_count(40));
        chk("R6 no up", n_up, 0);

        // R8: both held, then conflict in the middle of a hold
        cur_req = "R8";
        clear_counts();
        drive(1, 1, 0, 30);
        drive(0, 0, 0, 4);
        chk("R8 both count", n_up + n_dn, 0);
        clear_counts();
        drive(1, 0, 0, 12);
        drive(1, 1, 0, 3);
        drive(1, 0, 0, 12);
        drive(0, 0, 0, 6);
        chk("R8 restart count", n_up, 2);

        // R7: lock held throughout, then lock pulse during a hold
        cur_req = "R7";
        clear_counts();
        drive(1, 0, 1, 40);
        drive(0, 0, 0, 6);
        chk("R7 locked count", n_up, 0);
        clear_counts();
        drive(1, 0, 0, 10);
        drive(1, 0, 1, 3);
        drive(1, 0, 0, 30);
        drive(0, 0, 0, 6);

        // R9: one-cycle release restarts everything
        cur_req = "R9";
        clear_counts();
        drive(1, 0, 0, 24);
        drive(0, 0, 0, 1);
        drive(1, 0, 0, 24);
        drive(0, 0, 0, 6);
        chk("R9 glitch count", n_up, 2);

        // R10: exercised by every strobe observed; alternate directions quickly
        cur_req = "R10";
        drive(1, 0, 0, 8);
        drive(0, 1, 0, 8);
        drive(0, 0, 0, 6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule